// File: doc/BRIEF.md
# Value-Capturing Issue Queue

This block holds a handful of decoded instructions between rename and execution. Each held instruction carries an opcode, the reorder-buffer tag of its own result, and two source operand slots. A slot holds either the operand's data or, while the producer is still in flight, the reorder-buffer tag of that producer. The queue therefore never reads a register file at issue time: every operand value it sends to a functional unit comes from the queue itself.

Completed results arrive on a broadcast bus as a tag and a value. On every cycle, each waiting slot compares its tag with the bus. A slot whose tag matches latches the value and becomes ready. An instruction whose two slots are both ready can be selected. Among those candidates, the one placed in the queue earliest goes to execution first. At most one instruction leaves per cycle. Dispatch is refused while the queue is full. A misprediction flush empties the queue in one cycle.

Top module: `iq_value_capture`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `iss_valid`=0.
- R2: An instruction dispatched with both operands marked ready is presented on the issue port in the following cycle. The issue port carries its opcode, destination tag and both operand values unchanged.
- R3: A waiting operand latches the broadcast value when `bc_valid`=1 and `bc_tag` equals its stored tag. A broadcast with any other tag leaves the operand waiting.
- R4: A broadcast in the same cycle as a dispatch is captured by the instruction being dispatched, when it matches one of that instruction's waiting operands.
- R5: An instruction is not issued while either of its operands is still waiting.
- R6: Once an operand holds a value, later broadcasts carrying its old tag do not change that value.
- R7: When several held instructions are ready, the earliest dispatched one issues first, whatever slot it occupies. Exactly one instruction issues per cycle while any is ready.
- R8: `full`=1 when DEPTH instructions are held. In that state `disp_accept`=0, and the refused instruction is not stored.
- R9: `flush`=1 discards every held instruction: `empty`=1 in the next cycle, and a broadcast afterwards issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all held instructions |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of dispatched instruction |
| disp_dst | input | TAG_W | Reorder-buffer tag of its result |
| disp_a_rdy | input | 1 | Operand A carries data (1) or a tag (0) |
| disp_a_val | input | DATA_W | Operand A data |
| disp_a_tag | input | TAG_W | Operand A producer tag |
| disp_b_rdy | input | 1 | Operand B carries data (1) or a tag (0) |
| disp_b_val | input | DATA_W | Operand B data |
| disp_b_tag | input | TAG_W | Operand B producer tag |
| disp_accept | output | 1 | Dispatch taken this cycle |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_a | output | DATA_W | Issued operand A value |
| iss_b | output | DATA_W | Issued operand B value |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slots occupied |

## Verification
The main path is exercised with a table of instructions whose operands are all ready. This shows that opcode, tag and both values pass through without being mixed between fields. Instructions with one waiting operand are then driven against broadcasts with a wrong tag, a right tag, and a right tag arriving together with the dispatch. These cases separate real tag matching from plain timing, and show that the dispatch cycle is not missed. Instructions with two waiting operands separate "one ready" from "both ready". A tag repeated after capture shows whether held data is overwritten. The order test places an older instruction in a higher slot than a younger one. A slot-index picker therefore fails where an age-ordered picker passes. The full and flush tests confirm, through the issue port, that nothing refused or discarded survives.

// File: rtl/iqv_pkg.sv
package iqv_pkg;
   localparam int unsigned IQV_DEPTH  = 4;
   localparam int unsigned IQV_DATA_W = 16;
   localparam int unsigned IQV_TAG_W  = 3;
   localparam int unsigned IQV_OP_W   = 4;

   // source of an operand at dispatch
   typedef enum logic {
      SRC_TAG  = 1'b0,
      SRC_DATA = 1'b1
   } iqv_src_e;
endpackage

// File: rtl/iqv_operand.sv
module iqv_operand #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_src,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   import iqv_pkg::*;

   logic              rdy_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              hit_wait, hit_load;

   assign hit_wait = !rdy_q && bc_valid && (bc_tag == tag_q);
   assign hit_load = bc_valid && (bc_tag == ld_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         tag_q <= '0;
         val_q <= '0;
      end else if (load) begin
         tag_q <= ld_tag;
         if (iqv_src_e'(ld_src) == SRC_DATA) begin
            rdy_q <= 1'b1;
            val_q <= ld_val;
         end else if (hit_load) begin
            rdy_q <= 1'b1;
            val_q <= bc_val;
         end else begin
            rdy_q <= 1'b0;
         end
      end else if (hit_wait) begin
         rdy_q <= 1'b1;
         val_q <= bc_val;
      end
   end

   assign rdy = rdy_q;
   assign val = val_q;

   // R3: matching broadcast fills a waiting slot
   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !rdy && bc_valid && bc_tag == tag_q) |=> (rdy && val == $past(bc_val)));

   // R4: broadcast in the dispatch cycle is not lost
   p_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ld_src && bc_valid && bc_tag == ld_tag) |=> (rdy && val == $past(bc_val)));

   // R6: held data is not overwritten without a new load
   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && rdy) |=> (rdy && $stable(val)));
endmodule

// File: rtl/iqv_age_pick.sv
module iqv_age_pick #(
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc,
   input  logic [DEPTH-1:0] live,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant
);
   // elder_q[i][j] = 1 : slot j was allocated before slot i
   logic [DEPTH-1:0] elder_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            elder_q[i] <= '0;
         end else if (alloc[i]) begin
            elder_q[i] <= live & ~(DEPTH'(1) << i);
         end else begin
            elder_q[i] <= elder_q[i] & ~alloc;
         end
      end
      assign grant[i] = req[i] && !(|(req & elder_q[i]));
   end

   // R7: one winner at most, and a winner whenever anyone asks
   p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_some_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|grant));
endmodule

// File: rtl/iq_value_capture.sv
module iq_value_capture #(
   parameter int unsigned DEPTH  = iqv_pkg::IQV_DEPTH,
   parameter int unsigned DATA_W = iqv_pkg::IQV_DATA_W,
   parameter int unsigned TAG_W  = iqv_pkg::IQV_TAG_W,
   parameter int unsigned OP_W   = iqv_pkg::IQV_OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              disp_valid,
   input  logic [OP_W-1:0]   disp_op,
   input  logic [TAG_W-1:0]  disp_dst,
   input  logic              disp_a_rdy,
   input  logic [DATA_W-1:0] disp_a_val,
   input  logic [TAG_W-1:0]  disp_a_tag,
   input  logic              disp_b_rdy,
   input  logic [DATA_W-1:0] disp_b_val,
   input  logic [TAG_W-1:0]  disp_b_tag,
   output logic              disp_accept,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [TAG_W-1:0]  iss_dst,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b,
   output logic              full,
   output logic              empty
);
   localparam int unsigned TAG_SPACE = 1 << TAG_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("iq_value_capture: DEPTH must be at least 2");
   end
   if (TAG_SPACE < DEPTH) begin : g_bad_tag
      $error("iq_value_capture: TAG_W too small for DEPTH");
   end
   if (DATA_W < 1 || OP_W < 1) begin : g_bad_width
      $error("iq_value_capture: DATA_W and OP_W must be positive");
   end

   logic [DEPTH-1:0]  valid_q;
   logic [OP_W-1:0]   op_q  [DEPTH];
   logic [TAG_W-1:0]  dst_q [DEPTH];
   logic [DEPTH-1:0]  rdy_a, rdy_b, req, grant, free_pick, load;
   logic [DATA_W-1:0] val_a [DEPTH];
   logic [DATA_W-1:0] val_b [DEPTH];

   assign full        = &valid_q;
   assign empty       = ~|valid_q;
   assign disp_accept = disp_valid && !full && !flush;

   // lowest free slot
   always_comb begin
      free_pick = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_pick = DEPTH'(1) << i;
      end
   end

   assign load = free_pick & {DEPTH{disp_accept}};
   assign req  = valid_q & rdy_a & rdy_b & {DEPTH{!flush}};

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      iqv_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opa (
         .clk(clk), .rst_n(rst_n), .load(load[i]),
         .ld_src(disp_a_rdy), .ld_val(disp_a_val), .ld_tag(disp_a_tag),
         .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
         .rdy(rdy_a[i]), .val(val_a[i])
      );
      iqv_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opb (
         .clk(clk), .rst_n(rst_n), .load(load[i]),
         .ld_src(disp_b_rdy), .ld_val(disp_b_val), .ld_tag(disp_b_tag),
         .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
         .rdy(rdy_b[i]), .val(val_b[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            op_q[i]  <= '0;
            dst_q[i] <= '0;
         end else if (load[i]) begin
            op_q[i]  <= disp_op;
            dst_q[i] <= disp_dst;
         end
      end
   end

   iqv_age_pick #(.DEPTH(DEPTH)) u_pick (
      .clk(clk), .rst_n(rst_n), .alloc(load), .live(valid_q),
      .req(req), .grant(grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= '0;
      else if (flush) valid_q <= '0;
      else            valid_q <= (valid_q & ~grant) | load;
   end

   always_comb begin
      iss_op  = '0;
      iss_dst = '0;
      iss_a   = '0;
      iss_b   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) begin
            iss_op  = iss_op  | op_q[i];
            iss_dst = iss_dst | dst_q[i];
            iss_a   = iss_a   | val_a[i];
            iss_b   = iss_b   | val_b[i];
         end
      end
   end
   assign iss_valid = |grant;

   // R8: nothing enters a full queue
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !disp_accept);
   // R9: flush leaves the queue empty
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   // R5: an issued slot had both operands present
   p_issue_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (|(valid_q & rdy_a & rdy_b)));
endmodule

// File: tb/iq_value_capture_bench.sv
module iq_value_capture_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, flush, disp_valid, disp_a_rdy, disp_b_rdy, bc_valid;
   logic [3:0]  disp_op;
   logic [2:0]  disp_dst, disp_a_tag, disp_b_tag, bc_tag;
   logic [15:0] disp_a_val, disp_b_val, bc_val;
   logic        disp_accept, iss_valid, full, empty;
   logic [3:0]  iss_op;
   logic [2:0]  iss_dst;
   logic [15:0] iss_a, iss_b;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   iq_value_capture u_iq_value_capture (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_a_rdy(disp_a_rdy), .disp_a_val(disp_a_val), .disp_a_tag(disp_a_tag),
      .disp_b_rdy(disp_b_rdy), .disp_b_val(disp_b_val), .disp_b_tag(disp_b_tag),
      .disp_accept(disp_accept),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_a(iss_a), .iss_b(iss_b), .full(full), .empty(empty)
   );

   // {op, dst, a, b}, all operands ready
   localparam logic [38:0] VEC [6] = '{
      {4'h1, 3'd0, 16'h0000, 16'hFFFF},
      {4'h2, 3'd5, 16'hFFFF, 16'h0000},
      {4'h7, 3'd2, 16'h1234, 16'h5678},
      {4'h8, 3'd7, 16'hA5A5, 16'h5A5A},
      {4'hF, 3'd3, 16'h8001, 16'h0001},
      {4'h0, 3'd6, 16'h00FF, 16'hFF00}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      disp_valid = 1'b0; flush = 1'b0; bc_valid = 1'b0;
      disp_op = '0; disp_dst = '0;
      disp_a_rdy = 1'b0; disp_a_val = '0; disp_a_tag = '0;
      disp_b_rdy = 1'b0; disp_b_val = '0; disp_b_tag = '0;
      bc_tag = '0; bc_val = '0;
   endtask

   task automatic put(input logic [3:0] op, input logic [2:0] dst,
                      input logic ar, input logic [15:0] av, input logic [2:0] at,
                      input logic br, input logic [15:0] bv, input logic [2:0] bt);
      disp_valid = 1'b1; disp_op = op; disp_dst = dst;
      disp_a_rdy = ar; disp_a_val = av; disp_a_tag = at;
      disp_b_rdy = br; disp_b_val = bv; disp_b_tag = bt;
   endtask

   task automatic bcast(input logic [2:0] t, input logic [15:0] v);
      bc_valid = 1'b1; bc_tag = t; bc_val = v;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      // R1
      chk(empty == 1'b1 && full == 1'b0 && iss_valid == 1'b0, "R1 reset state",
          {empty, full, iss_valid}, 3'b100);

      // R2: table of ready dispatches
      for (int k = 0; k < 6; k++) begin
         logic [38:0] v;
         v = VEC[k];
         put(v[38:35], v[34:32], 1'b1, v[31:16], 3'd0, 1'b1, v[15:0], 3'd0);
         cyc();
         idle();
         chk(iss_valid && iss_op == v[38:35] && iss_dst == v[34:32],
             "R2 issue op/dst", {iss_valid, iss_op, iss_dst}, {1'b1, v[38:32]});
         chk(iss_a == v[31:16] && iss_b == v[15:0], "R2 issue values",
             {iss_a, iss_b}, v[31:0]);
         cyc();
      end
      chk(empty, "R2 drained", empty, 1);

      // R3: wrong tag ignored, right tag captured
      put(4'h3, 3'd1, 1'b0, 16'h0, 3'd2, 1'b1, 16'h0B0B, 3'd0);
      cyc(); idle();
      bcast(3'd4, 16'hDEAD);
      cyc(); idle();
      chk(!iss_valid, "R3 wrong tag ignored", iss_valid, 0);
      bcast(3'd2, 16'h2222);
      cyc(); idle();
      chk(iss_valid && iss_a == 16'h2222 && iss_b == 16'h0B0B, "R3 captured",
          {iss_a, iss_b}, {16'h2222, 16'h0B0B});
      cyc();

      // R4: broadcast in dispatch cycle
      put(4'h5, 3'd1, 1'b0, 16'h0, 3'd3, 1'b1, 16'h00B0, 3'd0);
      bcast(3'd3, 16'h0A0A);
      cyc(); idle();
      chk(iss_valid && iss_a == 16'h0A0A && iss_b == 16'h00B0, "R4 same-cycle capture",
          {iss_valid, iss_a}, {1'b1, 16'h0A0A});
      cyc();
      chk(empty, "R4 drained", empty, 1);

      // R5: one ready, one waiting
      put(4'h6, 3'd4, 1'b0, 16'h0, 3'd2, 1'b0, 16'h0, 3'd3);
      cyc(); idle();
      bcast(3'd2, 16'h0202);
      cyc(); idle();
      chk(!iss_valid, "R5 half ready held", iss_valid, 0);
      bcast(3'd3, 16'h0303);
      cyc(); idle();
      chk(iss_valid && iss_a == 16'h0202 && iss_b == 16'h0303, "R5 both ready",
          {iss_a, iss_b}, {16'h0202, 16'h0303});
      cyc();

      // R6: repeated tag does not disturb held value
      put(4'h9, 3'd5, 1'b0, 16'h0, 3'd1, 1'b0, 16'h0, 3'd2);
      cyc(); idle();
      bcast(3'd1, 16'h0111);
      cyc(); idle();
      bcast(3'd1, 16'h0999);
      cyc(); idle();
      bcast(3'd2, 16'h0222);
      cyc(); idle();
      chk(iss_valid && iss_a == 16'h0111, "R6 value kept", iss_a, 16'h0111);
      cyc();

      // R7: older entry in higher slot wins
      put(4'h1, 3'd0, 1'b1, 16'h1, 3'd0, 1'b1, 16'h1, 3'd0);
      cyc(); idle();
      chk(iss_valid && iss_dst == 3'd0, "R7 setup issue", iss_dst, 0);
      put(4'hA, 3'd6, 1'b0, 16'h0, 3'd5, 1'b1, 16'h6, 3'd0);
      cyc(); idle();
      put(4'hB, 3'd7, 1'b0, 16'h0, 3'd5, 1'b1, 16'h7, 3'd0);
      cyc(); idle();
      bcast(3'd5, 16'h0555);
      cyc(); idle();
      chk(iss_valid && iss_dst == 3'd6 && iss_op == 4'hA, "R7 oldest first",
          iss_dst, 6);
      cyc();
      chk(iss_valid && iss_dst == 3'd7 && iss_op == 4'hB, "R7 younger next",
          iss_dst, 7);
      cyc();
      chk(empty && !iss_valid, "R7 drained", {empty, iss_valid}, 2'b10);

      // R8: full and refusal
      for (int k = 0; k < 4; k++) begin
         put(4'(k + 4), 3'(k), 1'b0, 16'h0, 3'd6, 1'b1, 16'(k), 3'd0);
         cyc(); idle();
      end
      chk(full && !empty, "R8 full flag", {full, empty}, 2'b10);
      put(4'hE, 3'd7, 1'b1, 16'hEEEE, 3'd0, 1'b1, 16'hEEEE, 3'd0);
      #1;
      chk(!disp_accept, "R8 refuse when full", disp_accept, 0);
      cyc(); idle();
      chk(!iss_valid, "R8 refused not issued", iss_valid, 0);
      bcast(3'd6, 16'h6666);
      cyc(); idle();
      for (int k = 0; k < 4; k++) begin
         chk(iss_valid && iss_dst == 3'(k) && iss_a == 16'h6666, "R7 R8 order drain",
             iss_dst, k);
         cyc();
      end
      chk(empty && !iss_valid, "R8 refused not stored", {empty, iss_valid}, 2'b10);

      // R9: flush
      put(4'h2, 3'd1, 1'b0, 16'h0, 3'd4, 1'b1, 16'h1, 3'd0);
      cyc(); idle();
      put(4'h3, 3'd2, 1'b0, 16'h0, 3'd4, 1'b1, 16'h2, 3'd0);
      cyc(); idle();
      flush = 1'b1;
      cyc(); idle();
      chk(empty && !full, "R9 empty after flush", empty, 1);
      bcast(3'd4, 16'h4444);
      cyc(); idle();
      chk(!iss_valid, "R9 nothing issues after flush", iss_valid, 0);

      finish_run();
   end
endmodule